// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Block Refill

This block sits between a processor's word-wide load/store port and a main memory that moves one word per handshake beat. Each 32-bit byte address is cut into four fields: the low two bits pick a byte, the next `WORD_W` bits pick a word inside a block, the next `INDEX_W` bits pick one of the cache lines, and all remaining upper bits form the tag. Every line keeps its tag, a valid flag and a modified flag next to its block of data words. A block has exactly one line it may live in, so no replacement choice is ever made.

An access that finds a valid line with a matching tag completes in the cycle it is presented. When the line does not match, the controller stalls the processor. If the line it must replace holds modified data, it first copies the old block out to memory. It then reads the new block in, word by word, and finishes the access from the refilled line. The `WRITE_THROUGH` parameter selects the write policy. With it clear, a store only updates the cache and marks the line modified. With it set, every store is also sent to memory before the processor is released, and lines are never marked modified.

Top module: `dm_cache`

## Requirements
- R1: Address bits [1:0] select a byte and have no effect on which word is accessed, bits [WORD_W+1:2] select the word in a block, the next INDEX_W bits select the line, and the remaining high bits are the tag.
- R2: Reset clears every valid and modified flag, so the first access to any line misses and causes no memory write.
- R3: `cpu_hit` is high in the first cycle of an access exactly when the indexed line is valid and its stored tag equals the address tag; it is never high while a memory beat is requested.
- R4: A load that hits returns the addressed word on `cpu_rdata` with `cpu_stall` low in the same cycle.
- R5: On a miss the line is refilled with read beats for words 0 to block size minus 1, and the access then completes with the word from memory.
- R6: With WRITE_THROUGH=0, a store that hits completes without stalling, updates only the cache, and leaves main memory unchanged.
- R7: When a missing access replaces a line that is valid and modified, all words of the old block are written to memory at the old tag's addresses before any read beat of the refill.
- R8: Replacing a line that is invalid or unmodified issues no memory write.
- R9: With WRITE_THROUGH=1, each store writes its word to memory (one write beat) before the access completes, and a later replacement of that line issues no write-back.
- R10: A memory beat is requested with `mem_valid` high and is held with unchanged address and direction until `mem_ready` is seen high; one word moves per accepted beat.
- R11: `cpu_stall` is high while a requested access is not yet complete and is low whenever `cpu_req` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, held until stall is low |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Load data, valid when stall is low |
| cpu_hit | output | 1 | Lookup matched in the first cycle of an access |
| cpu_stall | output | 1 | Access not yet complete |
| mem_valid | output | 1 | Memory beat requested |
| mem_ready | input | 1 | Memory accepts the beat this cycle |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | ADDR_W | Word-aligned byte address of the beat |
| mem_wdata | output | DATA_W | Data of a write beat |
| mem_rdata | input | DATA_W | Data of a read beat, valid while ready is high |

## Verification
A wrong stored tag or a lost valid flag shows at the ports on the very next access to that line, either as a hit that returns another block's word or as a miss with refill beats that should not occur. A modified flag that is lost or set by mistake stays hidden until the line is replaced. The bench therefore forces conflicting accesses to the same index and counts the write beats and their order at the memory side. It also reads the old address again, so that a block that was written back wrongly comes back to the processor with a wrong value.

// File: rtl/dm_cache.sv
module dm_cache #(
  parameter int ADDR_W        = 32,
  parameter int DATA_W        = 32,
  parameter int BYTE_W        = 2,
  parameter int WORD_W        = 2,
  parameter int INDEX_W       = 7,
  parameter bit WRITE_THROUGH = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_hit,
  output logic              cpu_stall,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int TAG_W = ADDR_W - BYTE_W - WORD_W - INDEX_W;
  localparam int LINES = 1 << INDEX_W;
  localparam int BLK   = 1 << WORD_W;
  localparam logic [WORD_W-1:0] LAST = WORD_W'(BLK - 1);

  typedef enum logic [1:0] {S_IDLE, S_EVICT, S_FILL, S_THRU} st_t;
  st_t st;

  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] data_q [LINES*BLK];
  logic [LINES-1:0]  valid_q, dirty_q;
  logic [WORD_W-1:0] cnt;

  wire [TAG_W-1:0]   a_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
  wire [INDEX_W-1:0] a_idx  = cpu_addr[BYTE_W+WORD_W +: INDEX_W];
  wire [WORD_W-1:0]  a_word = cpu_addr[BYTE_W +: WORD_W];

  wire match   = valid_q[a_idx] && (tag_q[a_idx] == a_tag);
  wire lookup  = cpu_req && (st == S_IDLE);
  wire beat    = mem_valid && mem_ready;
  wire hit_wr  = lookup && match && cpu_we && !WRITE_THROUGH;
  wire fill_wr = (st == S_FILL) && mem_ready;
  wire thru_wr = (st == S_THRU) && mem_ready;
  wire done    = (lookup && match && !(WRITE_THROUGH && cpu_we)) || thru_wr;

  assign cpu_hit   = lookup && match;
  assign cpu_stall = cpu_req && !done;
  assign cpu_rdata = data_q[{a_idx, a_word}];

  assign mem_valid = (st != S_IDLE);
  assign mem_we    = (st == S_EVICT) || (st == S_THRU);
  assign mem_wdata = (st == S_THRU) ? cpu_wdata : data_q[{a_idx, cnt}];

  always_comb begin
    case (st)
      S_EVICT: mem_addr = {tag_q[a_idx], a_idx, cnt, {BYTE_W{1'b0}}};
      S_FILL:  mem_addr = {a_tag, a_idx, cnt, {BYTE_W{1'b0}}};
      default: mem_addr = {cpu_addr[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (cpu_req && !match)
            st <= (valid_q[a_idx] && dirty_q[a_idx]) ? S_EVICT : S_FILL;
          else if (cpu_req && cpu_we && WRITE_THROUGH)
            st <= S_THRU;
          if (hit_wr) dirty_q[a_idx] <= 1'b1;
        end
        S_EVICT: if (beat) begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) st <= S_FILL;
        end
        S_FILL: if (beat) begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) begin
            st             <= S_IDLE;
            valid_q[a_idx] <= 1'b1;
            dirty_q[a_idx] <= 1'b0;
          end
        end
        default: if (beat) st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (fill_wr && cnt == LAST) tag_q[a_idx] <= a_tag;
    if (fill_wr) data_q[{a_idx, cnt}] <= mem_rdata;
    else if (hit_wr || thru_wr) data_q[{a_idx, a_word}] <= cpu_wdata;
  end
endmodule

// File: rtl/dm_cache_chk.sv
module dm_cache_chk #(
  parameter int ADDR_W = 32,
  parameter int BYTE_W = 2,
  parameter bit WT     = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_hit,
  input logic              cpu_stall,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr
);
  AST_NO_REQ_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_req |-> !cpu_stall); // R11
  AST_HIT_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_hit && mem_valid)); // R3
  AST_LOAD_HIT_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_hit && !cpu_we) |-> !cpu_stall); // R4
  AST_WB_STORE_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (!WT && cpu_req && cpu_hit) |-> !cpu_stall); // R6
  AST_BEAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we))); // R10
  AST_WT_WRITE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (WT && mem_valid && mem_we) |->
      (cpu_req && cpu_we && mem_addr[ADDR_W-1:BYTE_W] == cpu_addr[ADDR_W-1:BYTE_W])); // R9
endmodule

bind dm_cache dm_cache_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .WT(WRITE_THROUGH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
  .cpu_hit(cpu_hit), .cpu_stall(cpu_stall), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/dm_cache_bench.sv
module dm_cache_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        req = 0, we = 0, sel = 0, slow = 0, tick = 0;
  logic [31:0] addr = 0, wdata = 0;
  int n_chk = 0, n_fail = 0;

  logic [31:0] rd_a, rd_b, ma_a, ma_b, wd_a, wd_b, md_a, md_b;
  logic hit_a, hit_b, st_a, st_b, mv_a, mv_b, mw_a, mw_b;
  wire rdy = !slow || tick;

  dm_cache u_dm_cache (
    .clk(clk), .rst_n(rst_n), .cpu_req(req && !sel), .cpu_we(we), .cpu_addr(addr),
    .cpu_wdata(wdata), .cpu_rdata(rd_a), .cpu_hit(hit_a), .cpu_stall(st_a),
    .mem_valid(mv_a), .mem_ready(rdy), .mem_we(mw_a), .mem_addr(ma_a),
    .mem_wdata(wd_a), .mem_rdata(md_a));

  dm_cache #(.WRITE_THROUGH(1'b1)) u_dm_cache_wt (
    .clk(clk), .rst_n(rst_n), .cpu_req(req && sel), .cpu_we(we), .cpu_addr(addr),
    .cpu_wdata(wdata), .cpu_rdata(rd_b), .cpu_hit(hit_b), .cpu_stall(st_b),
    .mem_valid(mv_b), .mem_ready(rdy), .mem_we(mw_b), .mem_addr(ma_b),
    .mem_wdata(wd_b), .mem_rdata(md_b));

  logic [31:0] mem_a [logic [29:0]];
  logic [31:0] mem_b [logic [29:0]];
  int wr_cnt = 0, rd_cnt = 0, order_err = 0;

  function automatic logic [31:0] init_val(logic [29:0] k);
    return {k, 2'b00} ^ 32'hA5A5_0000;
  endfunction
  function automatic logic [31:0] A(int t, int i, int w);
    return {t[20:0], i[6:0], w[1:0], 2'b00};
  endfunction

  always_comb md_a = mem_a.exists(ma_a[31:2]) ? mem_a[ma_a[31:2]] : init_val(ma_a[31:2]);
  always_comb md_b = mem_b.exists(ma_b[31:2]) ? mem_b[ma_b[31:2]] : init_val(ma_b[31:2]);

  always @(posedge clk) begin
    tick <= ~tick;
    if (mv_a && rdy && !sel) begin
      if (mw_a) begin mem_a[ma_a[31:2]] = wd_a; wr_cnt++; if (rd_cnt != 0) order_err++; end
      else rd_cnt++;
    end
    if (mv_b && rdy && sel) begin
      if (mw_b) begin mem_b[ma_b[31:2]] = wd_b; wr_cnt++; if (rd_cnt != 0) order_err++; end
      else rd_cnt++;
    end
  end

  function automatic logic [31:0] peek(logic s, logic [31:0] a);
    if (!s) return mem_a.exists(a[31:2]) ? mem_a[a[31:2]] : init_val(a[31:2]);
    return mem_b.exists(a[31:2]) ? mem_b[a[31:2]] : init_val(a[31:2]);
  endfunction

  task automatic check(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  logic [31:0] o_data; logic o_hit; int o_cyc;
  task automatic access(logic w, logic [31:0] a, logic [31:0] d);
    @(negedge clk);
    wr_cnt = 0; rd_cnt = 0; order_err = 0;
    req = 1; we = w; addr = a; wdata = d;
    #1;
    o_hit = sel ? hit_b : hit_a;
    o_cyc = 0;
    while (sel ? st_b : st_a) begin
      @(negedge clk); #1; o_cyc++;
    end
    o_data = sel ? rd_b : rd_a;
    @(posedge clk); #1;
    req = 0; we = 0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R11 stall idle", {31'b0, st_a}, 0);
    check("R10 no beat idle", {31'b0, mv_a}, 0);
  endtask

  task automatic t_read_miss;
    access(0, A(1, 5, 2), 0);
    check("R2 first access misses", {31'b0, o_hit}, 0);
    check("R2 no write after reset", wr_cnt, 0);
    check("R5 refill beats", rd_cnt, 4);
    check("R5 miss data", o_data, init_val(A(1, 5, 2) >> 2));
    check("R11 stalled during miss", {31'b0, o_cyc > 0}, 1);
    access(0, A(1, 5, 2), 0);
    check("R3 hit after refill", {31'b0, o_hit}, 1);
    check("R4 hit no stall", o_cyc, 0);
    check("R4 hit data", o_data, init_val(A(1, 5, 2) >> 2));
  endtask

  task automatic t_fields;
    access(0, A(1, 5, 0), 0);
    check("R5 whole block filled", {31'b0, o_hit}, 1);
    check("R5 word0 data", o_data, init_val(A(1, 5, 0) >> 2));
    access(0, A(1, 5, 3) | 32'h3, 0);
    check("R1 byte offset ignored hit", {31'b0, o_hit}, 1);
    check("R1 byte offset ignored data", o_data, init_val(A(1, 5, 3) >> 2));
  endtask

  task automatic t_delayed_write;
    access(1, A(1, 5, 1), 32'hDEAD_0001);
    check("R6 store hit no stall", o_cyc, 0);
    check("R6 no memory write", wr_cnt, 0);
    check("R6 memory unchanged", peek(0, A(1, 5, 1)), init_val(A(1, 5, 1) >> 2));
    access(0, A(1, 5, 1), 0);
    check("R6 cache holds store", o_data, 32'hDEAD_0001);
  endtask

  task automatic t_evict;
    access(0, A(2, 5, 0), 0);
    check("R3 conflict misses", {31'b0, o_hit}, 0);
    check("R7 write-back beats", wr_cnt, 4);
    check("R7 write-back before refill", order_err, 0);
    check("R7 victim data in memory", peek(0, A(1, 5, 1)), 32'hDEAD_0001);
    check("R7 new block data", o_data, init_val(A(2, 5, 0) >> 2));
    access(0, A(1, 5, 1), 0);
    check("R8 clean victim no write", wr_cnt, 0);
    check("R7 old block returns", o_data, 32'hDEAD_0001);
  endtask

  task automatic t_slow;
    slow = 1;
    access(0, A(3, 9, 2), 0);
    check("R10 beats with wait states", rd_cnt, 4);
    check("R10 data with wait states", o_data, init_val(A(3, 9, 2) >> 2));
    access(1, A(3, 9, 3), 32'h1234_5678);
    access(0, A(7, 9, 0), 0);
    check("R10 slow write-back beats", wr_cnt, 4);
    check("R10 slow write-back data", peek(0, A(3, 9, 3)), 32'h1234_5678);
    slow = 0;
  endtask

  task automatic t_write_through;
    sel = 1;
    access(0, A(4, 7, 0), 0);
    access(1, A(4, 7, 0), 32'hCAFE_0000);
    check("R9 hit store stalls", {31'b0, o_cyc > 0}, 1);
    check("R9 one write beat", wr_cnt, 1);
    check("R9 memory updated", peek(1, A(4, 7, 0)), 32'hCAFE_0000);
    access(0, A(4, 7, 0), 0);
    check("R9 cache updated", o_data, 32'hCAFE_0000);
    access(0, A(5, 7, 0), 0);
    check("R9 no write-back", wr_cnt, 0);
    access(1, A(6, 3, 1), 32'hBEEF_0003);
    check("R9 store miss writes memory", peek(1, A(6, 3, 1)), 32'hBEEF_0003);
    check("R9 store miss single write", wr_cnt, 1);
    sel = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_read_miss();
    t_fields();
    t_delayed_write();
    t_evict();
    t_slow();
    t_write_through();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule